// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block translates 32-bit virtual addresses into 32-bit physical addresses for a 4 KB page size. It holds 64 translations. Every stored translation carries a 6-bit process identifier, so translations from several address spaces can sit in the buffer at once. The upper 20 address bits are the virtual page number, and all 64 entries compare that number in parallel. The lower 12 bits are the page offset, which passes through unchanged.

A lookup is matched against the current-process register. Each lookup returns exactly one of three results, one cycle after the request: a hit with the translated address, a miss, or a write-protection fault. The fault is raised when a write hits an entry whose write-enable flag is clear. An external page walker or software installs new translations through a refill port. A flush port invalidates every entry, or only the entries that belong to one process.

Top module: `tagged_tlb`

## Requirements
- R1: A granted hit returns `rsp_paddr` = {entry physical page (20 bits), request address bits 11:0}. When there is no granted hit, `rsp_paddr` is zero.
- R2: Any of the 64 entries can hold any translation. A lookup whose page number and process ID match a valid entry, and that is not a faulting write, returns `rsp_hit`=1. If several entries match, the lowest-index entry is used.
- R3: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_wfault` is high. While it is low, all three are low.
- R4: A lookup that matches no valid entry on both page number and process ID returns `rsp_miss`=1.
- R5: A write lookup (`req_write`=1) that matches an entry whose write-enable flag (`fill_wr_ok` when the entry was installed) is 0 returns `rsp_wfault`=1 and `rsp_hit`=0. A read lookup to the same entry hits.
- R6: A match requires the entry's process ID to equal the current-process register. A write through `pid_wr_en` changes the register for lookups in later cycles only. A lookup in the same cycle as the write uses the old value.
- R7: A refill writes the lowest-index invalid entry. If no entry is invalid, the refill writes the entry at a replacement pointer. That pointer resets to 0 and advances by one, wrapping after 63, for each refill that replaces a valid entry.
- R8: `flush_all` invalidates every entry. A lookup in the same cycle sees the contents from before the flush. A refill in the same cycle is installed after the flush and survives it.
- R9: `flush_pid_en` invalidates only the entries whose process ID equals `flush_pid_id`. Entries of other processes keep hitting.
- R10: A lookup in the same cycle as a refill sees the contents from before the refill. The new translation hits from the next cycle on.
- R11: After reset, all entries are invalid, the current-process register is 0, and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pid_wr_en | input | 1 | Load the current-process register |
| pid_wr_val | input | 6 | New current-process value |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Lookup is a write access |
| req_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pid | input | 6 | Process ID of the installed translation |
| fill_ppn | input | 20 | Physical page number to install |
| fill_wr_ok | input | 1 | Write-enable flag of the installed translation |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid_id | input | 6 | Process whose entries are invalidated |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_hit | output | 1 | Translation granted |
| rsp_miss | output | 1 | No matching translation |
| rsp_wfault | output | 1 | Write to a write-protected page |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
A lookup can share a cycle with a refill, a flush of either kind, or a process-register write. Each of these cases has a defined old-state-first ordering. Directed steps place each pairing in one cycle: a lookup together with a fill of the same page, with a full flush, and with a process switch, plus a flush together with a fill. A long random phase then mixes all of these operations freely over a small set of pages and processes. A behavioural model in the bench applies the stated ordering and predicts the result of every cycle, and the outputs are compared with it.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  parameter int unsigned TLB_ENTRIES = 64;
  parameter int unsigned TLB_VPN_W   = 20;
  parameter int unsigned TLB_PPN_W   = 20;
  parameter int unsigned TLB_OFS_W   = 12;
  parameter int unsigned TLB_PID_W   = 6;
endpackage

// File: rtl/tlb_store.sv
`timescale 1ns/1ps
module tlb_store #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned PID_W   = 6,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [VPN_W-1:0]                wr_vpn,
  input  logic [PID_W-1:0]                wr_pid,
  input  logic [PPN_W-1:0]                wr_ppn,
  input  logic                            wr_ok,
  input  logic                            clr_all,
  input  logic                            clr_pid_en,
  input  logic [PID_W-1:0]                clr_pid,
  input  logic [VPN_W-1:0]                lk_vpn,
  input  logic [PID_W-1:0]                lk_pid,
  output logic [ENTRIES-1:0]              valid_vec,
  output logic [ENTRIES-1:0]              match_vec,
  output logic [ENTRIES-1:0]              wok_vec,
  output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_arr,
  output logic [ENTRIES-1:0][PID_W-1:0]   pid_arr
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             v_q, v_d;
    logic             load, kill;
    logic             ok_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic [PID_W-1:0] pid_q;

    assign load = wr_en && (wr_idx == IDX_W'(e));
    assign kill = clr_all || (clr_pid_en && (pid_q == clr_pid));

    // invalidate first, then a refill of this slot wins
    always_comb begin
      v_d = v_q;
      if (kill) v_d = 1'b0;
      if (load) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (load) begin
        vpn_q <= wr_vpn;
        ppn_q <= wr_ppn;
        pid_q <= wr_pid;
        ok_q  <= wr_ok;
      end
    end

    assign valid_vec[e] = v_q;
    assign match_vec[e] = v_q && (vpn_q == lk_vpn) && (pid_q == lk_pid);
    assign wok_vec[e]   = ok_q;
    assign ppn_arr[e]   = ppn_q;
    assign pid_arr[e]   = pid_q;
  end
endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign victim_idx = free_found ? free_idx : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (fill_en && !free_found) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/tlb_resp.sv
`timescale 1ns/1ps
module tlb_resp #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned OFS_W   = 12,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned PA_W   = PPN_W + OFS_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [OFS_W-1:0]              req_ofs,
  input  logic [ENTRIES-1:0]            match_vec,
  input  logic [ENTRIES-1:0]            wok_vec,
  input  logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic                          rsp_miss,
  output logic                          rsp_wfault,
  output logic [PA_W-1:0]               rsp_paddr
);
  logic [IDX_W-1:0] sel;
  logic             any;
  logic             hit_d, miss_d, flt_d;
  logic [PA_W-1:0]  pa_d;

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    miss_d = req_valid && !any;
    flt_d  = req_valid && any && req_write && !wok_vec[sel];
    hit_d  = req_valid && any && !(req_write && !wok_vec[sel]);
    pa_d   = hit_d ? {ppn_arr[sel], req_ofs} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_wfault <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= hit_d;
      rsp_miss   <= miss_d;
      rsp_wfault <= flt_d;
      rsp_paddr  <= pa_d;
    end
  end
endmodule

// File: rtl/tagged_tlb.sv
`timescale 1ns/1ps
module tagged_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_ENTRIES,
  parameter int unsigned VPN_W   = TLB_VPN_W,
  parameter int unsigned PPN_W   = TLB_PPN_W,
  parameter int unsigned OFS_W   = TLB_OFS_W,
  parameter int unsigned PID_W   = TLB_PID_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned VA_W   = VPN_W + OFS_W,
  localparam int unsigned PA_W   = PPN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pid_wr_en,
  input  logic [PID_W-1:0] pid_wr_val,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr_ok,
  input  logic             flush_all,
  input  logic             flush_pid_en,
  input  logic [PID_W-1:0] flush_pid_id,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_wfault,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [PID_W-1:0]              cur_pid_q, cur_pid_d;
  logic [ENTRIES-1:0]            valid_vec, match_vec, wok_vec;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr;
  logic [ENTRIES-1:0][PID_W-1:0] pid_arr;
  logic [IDX_W-1:0]              victim_idx;

  always_comb begin
    cur_pid_d = cur_pid_q;
    if (pid_wr_en) cur_pid_d = pid_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_pid_q <= '0;
    else        cur_pid_q <= cur_pid_d;
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_valid),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx)
  );

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (fill_valid),
    .wr_idx     (victim_idx),
    .wr_vpn     (fill_vpn),
    .wr_pid     (fill_pid),
    .wr_ppn     (fill_ppn),
    .wr_ok      (fill_wr_ok),
    .clr_all    (flush_all),
    .clr_pid_en (flush_pid_en),
    .clr_pid    (flush_pid_id),
    .lk_vpn     (req_vaddr[VA_W-1:OFS_W]),
    .lk_pid     (cur_pid_q),
    .valid_vec  (valid_vec),
    .match_vec  (match_vec),
    .wok_vec    (wok_vec),
    .ppn_arr    (ppn_arr),
    .pid_arr    (pid_arr)
  );

  tlb_resp #(
    .ENTRIES(ENTRIES), .PPN_W(PPN_W), .OFS_W(OFS_W)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ofs    (req_vaddr[OFS_W-1:0]),
    .match_vec  (match_vec),
    .wok_vec    (wok_vec),
    .ppn_arr    (ppn_arr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_wfault (rsp_wfault),
    .rsp_paddr  (rsp_paddr)
  );
endmodule

// File: rtl/tagged_tlb_checker.sv
`timescale 1ns/1ps
module tagged_tlb_checker #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned PID_W   = 6,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_write,
  input logic [VA_W-1:0]               req_vaddr,
  input logic                          fill_valid,
  input logic                          flush_all,
  input logic                          flush_pid_en,
  input logic [PID_W-1:0]              flush_pid_id,
  input logic                          rsp_valid,
  input logic                          rsp_hit,
  input logic                          rsp_miss,
  input logic                          rsp_wfault,
  input logic [PA_W-1:0]               rsp_paddr,
  input logic [ENTRIES-1:0]            valid_vec,
  input logic [ENTRIES-1:0][PID_W-1:0] pid_arr
);
  assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_without_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_one_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_wfault}) == 1));
  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_wfault} == 3'b000));
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))));
  assert_paddr_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_paddr == '0));
  assert_fault_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> !rsp_wfault);
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all && !fill_valid |=> (valid_vec == '0));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_fp
    assert_flush_pid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pid_en && !fill_valid |=>
        !(valid_vec[e] && (pid_arr[e] == $past(flush_pid_id))));
  end
endmodule

bind tagged_tlb tagged_tlb_checker #(
  .ENTRIES(ENTRIES), .OFS_W(OFS_W), .PID_W(PID_W), .VA_W(VA_W), .PA_W(PA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_vaddr    (req_vaddr),
  .fill_valid   (fill_valid),
  .flush_all    (flush_all),
  .flush_pid_en (flush_pid_en),
  .flush_pid_id (flush_pid_id),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_wfault   (rsp_wfault),
  .rsp_paddr    (rsp_paddr),
  .valid_vec    (valid_vec),
  .pid_arr      (pid_arr)
);

// File: tb/test_tagged_tlb.sv
`timescale 1ns/1ps
module test_tagged_tlb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pid_wr_en = 1'b0;
  logic [5:0]  pid_wr_val = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [5:0]  fill_pid = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_wr_ok = 1'b0;
  logic        flush_all = 1'b0;
  logic        flush_pid_en = 1'b0;
  logic [5:0]  flush_pid_id = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_wfault;
  logic [31:0] rsp_paddr;

  tagged_tlb i_tagged_tlb (.*);

  always #2.5 clk = ~clk;  // 200 MHz

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_tag = "R11 reset";

  // ---------------- behavioural reference ----------------
  bit          m_v [N];
  bit          m_ok[N];
  int          m_vpn[N];
  int          m_pid[N];
  int          m_ppn[N];
  int          m_rr = 0;
  int          m_cur = 0;
  bit          e_valid = 0, e_hit = 0, e_miss = 0, e_flt = 0;
  logic [31:0] e_pa = '0;
  string       e_tag = "R11 reset";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_rr = 0; m_cur = 0;
      e_valid = 0; e_hit = 0; e_miss = 0; e_flt = 0; e_pa = '0;
    end else begin
      int hit_at, slot;
      hit_at = -1;
      if (req_valid) begin
        for (int i = 0; i < N; i++)
          if (hit_at < 0 && m_v[i] && m_vpn[i] == int'(req_vaddr[31:12]) && m_pid[i] == m_cur)
            hit_at = i;
      end
      e_valid = req_valid;
      e_miss  = req_valid && hit_at < 0;
      e_flt   = req_valid && hit_at >= 0 && req_write && !m_ok[hit_at];
      e_hit   = req_valid && hit_at >= 0 && !e_flt;
      e_pa    = e_hit ? {m_ppn[hit_at][19:0], req_vaddr[11:0]} : 32'h0;
      e_tag   = cur_tag;
      slot = -1;
      for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
      if (fill_valid && slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      for (int i = 0; i < N; i++)
        if (flush_all || (flush_pid_en && m_pid[i] == int'(flush_pid_id))) m_v[i] = 0;
      if (fill_valid) begin
        m_v[slot] = 1; m_ok[slot] = fill_wr_ok;
        m_vpn[slot] = int'(fill_vpn); m_pid[slot] = int'(fill_pid); m_ppn[slot] = int'(fill_ppn);
      end
      if (pid_wr_en) m_cur = int'(pid_wr_val);
    end
  end

  // ---------------- comparison on every clock ----------------
  task automatic cmp1(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", what, e_tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp1("R3 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      cmp1("R2 rsp_hit", 32'(rsp_hit), 32'(e_hit));
      cmp1("R4 rsp_miss", 32'(rsp_miss), 32'(e_miss));
      cmp1("R5 rsp_wfault", 32'(rsp_wfault), 32'(e_flt));
      cmp1("R1 rsp_paddr", rsp_paddr, e_pa);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clr();
    pid_wr_en = 0; req_valid = 0; req_write = 0; fill_valid = 0;
    flush_all = 0; flush_pid_en = 0;
  endtask
  task automatic step(); @(negedge clk); endtask
  task automatic look(int vpn, int ofs, bit wr, string tag);
    clr(); cur_tag = tag;
    req_valid = 1; req_write = wr; req_vaddr = {vpn[19:0], ofs[11:0]};
    step();
  endtask
  task automatic fill(int vpn, int pid, int ppn, bit ok, string tag);
    clr(); cur_tag = tag;
    fill_valid = 1; fill_vpn = vpn[19:0]; fill_pid = pid[5:0];
    fill_ppn = ppn[19:0]; fill_wr_ok = ok;
    step();
  endtask
  task automatic setpid(int p);
    clr(); pid_wr_en = 1; pid_wr_val = p[5:0]; step();
  endtask

  // ---------------- directed and random sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: empty after reset, current process 0
    look(20'h00010, 12'h123, 0, "R11 empty after reset");
    fill(20'h00010, 0, 20'hABCDE, 1, "R11 pid0 fill");
    look(20'h00010, 12'h123, 0, "R11 pid reg is 0");
    // R2 / R1 / R5
    setpid(3);
    fill(20'h12345, 3, 20'h00777, 1, "R2 fill rw");
    fill(20'h22222, 3, 20'h00888, 0, "R5 fill ro");
    look(20'h12345, 12'hFFF, 0, "R1 R2 read hit");
    look(20'h12345, 12'h001, 1, "R2 write hit");
    look(20'h22222, 12'h010, 1, "R5 write to ro page");
    look(20'h22222, 12'h020, 0, "R5 read of ro page");
    // R6: process tagging
    setpid(5);
    look(20'h12345, 12'h0, 0, "R6 other pid misses");
    fill(20'h12345, 5, 20'h00999, 1, "R6 same vpn pid5");
    look(20'h12345, 12'h004, 0, "R6 pid5 mapping");
    clr(); cur_tag = "R6 lookup with pid write";
    pid_wr_en = 1; pid_wr_val = 6'd3;
    req_valid = 1; req_vaddr = {20'h12345, 12'h008};
    step();
    look(20'h12345, 12'h00C, 0, "R6 new pid in effect");
    // R9: per-process flush
    clr(); flush_pid_en = 1; flush_pid_id = 6'd5; step();
    look(20'h12345, 12'h0, 0, "R9 pid3 survives");
    setpid(5);
    look(20'h12345, 12'h0, 0, "R9 pid5 gone");
    // R10: lookup in same cycle as refill
    clr(); cur_tag = "R10 lookup during fill";
    fill_valid = 1; fill_vpn = 20'h33333; fill_pid = 6'd5; fill_ppn = 20'h04444; fill_wr_ok = 1;
    req_valid = 1; req_vaddr = {20'h33333, 12'h0AA};
    step();
    look(20'h33333, 12'h0AA, 0, "R10 after fill");
    // R8: flush all with lookup, then flush with fill
    clr(); cur_tag = "R8 lookup during flush";
    flush_all = 1; req_valid = 1; req_vaddr = {20'h33333, 12'h055};
    step();
    look(20'h33333, 12'h055, 0, "R8 after flush");
    clr(); cur_tag = "R8 fill during flush";
    flush_all = 1; fill_valid = 1; fill_vpn = 20'h44444; fill_pid = 6'd5;
    fill_ppn = 20'h05555; fill_wr_ok = 0;
    step();
    look(20'h44444, 12'h321, 0, "R8 fill survives flush");
    // R7: overfill with 70 distinct pages
    for (int k = 0; k < 70; k++) fill(20'h50000 + k, 5, 20'h60000 + k, 1, "R7 overfill");
    for (int k = 0; k < 70; k += 3) look(20'h50000 + k, k, 0, "R7 replacement order");
    look(20'h44444, 12'h0, 0, "R7 oldest evicted");
    // random mix of all operations
    for (int c = 0; c < 4000; c++) begin
      int r;
      clr(); cur_tag = "R2 R4 R6 R7 R8 R9 R10 random";
      r = $urandom_range(0, 99);
      req_valid = (r < 60); req_write = $urandom_range(0, 1);
      req_vaddr = {16'h0, 4'($urandom_range(0, 15)), 12'($urandom)};
      fill_valid = ($urandom_range(0, 99) < 30);
      fill_vpn = 20'($urandom_range(0, 15)); fill_pid = 6'($urandom_range(0, 3));
      fill_ppn = 20'($urandom); fill_wr_ok = $urandom_range(0, 1);
      flush_all = ($urandom_range(0, 199) == 0);
      flush_pid_en = ($urandom_range(0, 49) == 0); flush_pid_id = 6'($urandom_range(0, 3));
      pid_wr_en = ($urandom_range(0, 19) == 0); pid_wr_val = 6'($urandom_range(0, 3));
      step();
    end
    clr(); step(); step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule